// File: doc/BRIEF.md
# Six-Digit Multiplexed Display Scanner

This block lets one BCD-to-segment decoder serve six seven-segment digits that are wired in parallel. It does this by time-division multiplexing. At any moment exactly one digit is lit. The scanner presents that digit's BCD value and its 3-bit select code to the shared decoder. It also drives a one-hot, active-high enable line for each of the six digits.

Digits are visited in ascending order, from select code 0 up to 5, and the scan then wraps back to 0. Each digit is held for the same dwell time. A prescaler sets that dwell to `CLK_HZ/1000` system clocks, which gives roughly a 1 kHz switching rate and no visible flicker.

The six BCD values live in a small register file that is loaded through a one-cycle write port. A write lands in a pending copy. The copy that is displayed takes on the pending values only at a slot boundary, so a lit digit never changes partway through its dwell. The same information also appears packed into one control byte: the system-enable bit, the select code and the BCD value.

Top module: `disp_scan_mux`

## Requirements
- R1: A synchronous reset, applied on a clock edge with `rst` high, has the following effect. After that edge `sel_code` is 0, every stored digit is 0, `digit_en` is all zero and `ctrl_byte` is 0x00.
- R2: `digit_en` never has more than one bit set. While the registered enable is 1, exactly bit `sel_code` is set.
- R3: `sel_code` only takes the values 0 to 5. It steps 0,1,2,3,4,5 and then returns to 0, one step per slot.
- R4: Every slot lasts exactly `CLK_HZ/1000` clock cycles. The first slot after reset ends on the `CLK_HZ/1000`-th edge after reset is released.
- R5: `ctrl_byte[7]` and the gating of `digit_en` follow `sys_en` with one clock of latency. While that enable is 0, `digit_en` is all zero and the scan keeps stepping.
- R6: A write changes the displayed value only from the next slot boundary on. A write on the same edge as a boundary becomes visible at the boundary after that.
- R7: `ctrl_byte` is packed as follows: bit 7 is the registered enable, bits 6:4 are `sel_code` and bits 3:0 are `bcd_out`.
- R8: Writes with `wr_addr` 6 or 7 have no effect on any displayed value.
- R9: Values 10 to 15 are stored and presented on `bcd_out` unchanged.
- R10: A write to address k sets the value that is shown while `sel_code` equals k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sys_en | input | 1 | Display power/enable request |
| wr_en | input | 1 | Write strobe for the digit store |
| wr_addr | input | 3 | Digit address for the write (0 to 5 valid) |
| wr_data | input | 4 | BCD value to store |
| bcd_out | output | 4 | BCD value of the digit now lit |
| sel_code | output | 3 | Select code of the digit now lit |
| digit_en | output | 6 | One-hot active-high digit enables |
| ctrl_byte | output | 8 | Packed {enable, select, BCD} byte |

## Verification
Every output comes from a register, so each result is due on the clock edge that follows its cause.

- `sys_en` shows up on `ctrl_byte[7]` and `digit_en` after one edge.
- A step of `sel_code` appears on the edge that ends a slot, which is the `CLK_HZ/1000`-th edge of that slot.
- A written value appears at `bcd_out` only once the scan lands on its digit after the next boundary.

The bench models the pending and displayed copies, the prescaler and the ring index behaviourally. It updates that model at each rising edge from the inputs driven half a cycle earlier. It compares every output at the following falling edge, so each expected value is sampled one edge after the stimulus that produced it. The directed checks use the same falling-edge sampling.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;
   localparam int BCD_W  = 4;
   localparam int SEL_W  = 3;
   localparam int BYTE_W = 1 + SEL_W + BCD_W;
   typedef logic [BCD_W-1:0] bcd_t;
   typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
   parameter int DWELL = 8
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;
   localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

   initial begin
      if (DWELL < 2) $error("slot_timer: DWELL must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)         cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);
endmodule

// File: rtl/digit_ring.sv
module digit_ring
   import disp_scan_pkg::*;
#(
   parameter int NUM = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   output sel_t idx
);
   localparam sel_t TOP = sel_t'(NUM - 1);

   always_ff @(posedge clk) begin
      if (rst)               idx <= '0;
      else if (step) begin
         if (idx == TOP)     idx <= '0;
         else                idx <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/digit_store.sv
module digit_store
   import disp_scan_pkg::*;
#(
   parameter int NUM = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic wr_en,
   input  sel_t wr_addr,
   input  bcd_t wr_data,
   input  logic commit,
   input  sel_t rd_idx,
   output bcd_t rd_data
);
   bcd_t pend [NUM];
   bcd_t live [NUM];

   for (genvar g = 0; g < NUM; g++) begin : g_cell
      always_ff @(posedge clk) begin
         if (rst) begin
            pend[g] <= '0;
            live[g] <= '0;
         end else begin
            if (commit)
               live[g] <= pend[g];
            if (wr_en && (wr_addr == sel_t'(g)))
               pend[g] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM; i++)
         if (rd_idx == sel_t'(i)) rd_data = live[i];
   end
endmodule

// File: rtl/sel_decoder.sv
module sel_decoder
   import disp_scan_pkg::*;
#(
   parameter int OUT_N = 6
) (
   input  logic             en,
   input  sel_t             code,
   output logic [OUT_N-1:0] y
);
   for (genvar g = 0; g < OUT_N; g++) begin : g_out
      assign y[g] = en && (code == sel_t'(g));
   end
endmodule

// File: rtl/disp_scan_mux.sv
module disp_scan_mux
   import disp_scan_pkg::*;
#(
   parameter int CLK_HZ     = 125_000_000,
   parameter int NUM_DIGITS = 6
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  sys_en,
   input  logic                  wr_en,
   input  logic [SEL_W-1:0]      wr_addr,
   input  logic [BCD_W-1:0]      wr_data,
   output logic [BCD_W-1:0]      bcd_out,
   output logic [SEL_W-1:0]      sel_code,
   output logic [NUM_DIGITS-1:0] digit_en,
   output logic [BYTE_W-1:0]     ctrl_byte
);
   localparam int DWELL = CLK_HZ / 1000;

   initial begin
      if (NUM_DIGITS < 2 || NUM_DIGITS > (1 << SEL_W))
         $error("disp_scan_mux: NUM_DIGITS out of range for select width");
      if (DWELL < 2)
         $error("disp_scan_mux: CLK_HZ too low for a 1 ms slot");
   end

   logic tick;
   logic en_q;
   sel_t idx;
   bcd_t cur;

   slot_timer #(.DWELL(DWELL)) u_timer (
      .clk (clk),
      .rst (rst),
      .tick(tick)
   );

   digit_ring #(.NUM(NUM_DIGITS)) u_ring (
      .clk (clk),
      .rst (rst),
      .step(tick),
      .idx (idx)
   );

   digit_store #(.NUM(NUM_DIGITS)) u_store (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .commit (tick),
      .rd_idx (idx),
      .rd_data(cur)
   );

   always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b0;
      else     en_q <= sys_en;
   end

   sel_decoder #(.OUT_N(NUM_DIGITS)) u_dec (
      .en  (en_q),
      .code(idx),
      .y   (digit_en)
   );

   assign sel_code  = idx;
   assign bcd_out   = cur;
   assign ctrl_byte = {en_q, idx, cur};
endmodule

// File: rtl/disp_scan_chk.sv
module disp_scan_chk
   import disp_scan_pkg::*;
#(
   parameter int NUM_DIGITS = 6,
   parameter int DWELL      = 8
) (
   input logic                  clk,
   input logic                  rst,
   input logic [BCD_W-1:0]      bcd_out,
   input logic [SEL_W-1:0]      sel_code,
   input logic [NUM_DIGITS-1:0] digit_en,
   input logic [BYTE_W-1:0]     ctrl_byte
);
   logic [SEL_W-1:0] prev_sel;
   int unsigned      run;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_sel <= '0;
         run      <= 0;
      end else begin
         prev_sel <= sel_code;
         run      <= (sel_code != prev_sel) ? 0 : run + 1;
      end
   end

   // R2
   a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(digit_en));
   // R2
   a_r2_lit_matches_sel: assert property (@(posedge clk) disable iff (rst)
      ctrl_byte[BYTE_W-1] |-> (digit_en == (NUM_DIGITS'(1) << sel_code)));
   // R3
   a_r3_sel_range: assert property (@(posedge clk) disable iff (rst)
      int'(sel_code) < NUM_DIGITS);
   // R3
   a_r3_step_order: assert property (@(posedge clk) disable iff (rst)
      (sel_code != $past(sel_code)) |->
         (int'(sel_code) == ((int'($past(sel_code)) + 1) % NUM_DIGITS)));
   // R4
   a_r4_dwell_bound: assert property (@(posedge clk) disable iff (rst)
      run <= DWELL);
   // R5
   a_r5_off_dark: assert property (@(posedge clk) disable iff (rst)
      !ctrl_byte[BYTE_W-1] |-> (digit_en == '0));
   // R6
   a_r6_hold_in_slot: assert property (@(posedge clk) disable iff (rst)
      (sel_code == $past(sel_code)) |-> $stable(bcd_out));
   // R7
   a_r7_packing: assert property (@(posedge clk) disable iff (rst)
      (ctrl_byte[BYTE_W-2:BCD_W] == sel_code) && (ctrl_byte[BCD_W-1:0] == bcd_out));
endmodule

bind disp_scan_mux disp_scan_chk #(
   .NUM_DIGITS(NUM_DIGITS),
   .DWELL     (CLK_HZ / 1000)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .bcd_out  (bcd_out),
   .sel_code (sel_code),
   .digit_en (digit_en),
   .ctrl_byte(ctrl_byte)
);

// File: tb/tb_disp_scan_mux.sv
`timescale 1ns/1ps
module tb_disp_scan_mux;
   localparam int CLK_HZ = 8000;
   localparam int DW     = CLK_HZ / 1000;
   localparam int ND     = 6;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sys_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [3:0] wr_data = '0;
   logic [3:0] bcd_out;
   logic [2:0] sel_code;
   logic [5:0] digit_en;
   logic [7:0] ctrl_byte;

   always #4 clk = ~clk;

   disp_scan_mux #(.CLK_HZ(CLK_HZ), .NUM_DIGITS(ND)) dut (
      .clk(clk), .rst(rst), .sys_en(sys_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .bcd_out(bcd_out),
      .sel_code(sel_code), .digit_en(digit_en), .ctrl_byte(ctrl_byte)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   // behavioural reference
   int m_cnt = 0, m_idx = 0, m_en = 0;
   int m_pend[$];
   int m_live[$];
   int m_steps = 0;
   bit m_valid = 0;

   initial begin
      for (int i = 0; i < ND; i++) begin
         m_pend.push_back(0);
         m_live.push_back(0);
      end
   end

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 0; m_idx = 0; m_en = 0; m_steps = 0; m_valid = 1;
         for (int i = 0; i < ND; i++) begin m_pend[i] = 0; m_live[i] = 0; end
      end else begin
         if (m_cnt == DW - 1) begin
            for (int i = 0; i < ND; i++) m_live[i] = m_pend[i];
            m_idx = (m_idx + 1) % ND;
            m_cnt = 0;
            m_steps++;
         end else m_cnt++;
         if (wr_en && int'(wr_addr) < ND) m_pend[wr_addr] = int'(wr_data);
         m_en = int'(sys_en);
      end
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (!rst && m_valid && !done) begin
         chk("R3 sel_code", int'(sel_code), m_idx);
         chk("R10 bcd_out", int'(bcd_out), m_live[m_idx]);
         chk("R2 digit_en", int'(digit_en), m_en ? (1 << m_idx) : 0);
         chk("R7 ctrl_byte", int'(ctrl_byte),
             (m_en << 7) | (m_idx << 4) | m_live[m_idx]);
      end
   end

   task automatic wr(int a, int d);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 4'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_sel(int s);
      while (int'(sel_code) != s) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 sel", int'(sel_code), 0);
      chk("R1 digit_en", int'(digit_en), 0);
      chk("R1 ctrl_byte", int'(ctrl_byte), 0);
      rst = 1'b0;
      // R4: first slot lasts exactly DW cycles
      repeat (DW - 1) @(negedge clk);
      chk("R4 still slot0", int'(sel_code), 0);
      @(negedge clk);
      chk("R4 step after DW", int'(sel_code), 1);
      // R5: enable latency one clock
      sys_en = 1'b1;
      chk("R5 before edge", int'(ctrl_byte[7]), 0);
      @(negedge clk);
      chk("R5 after edge", int'(ctrl_byte[7]), 1);
      // R10 and R8: load digits, junk to 6 and 7
      for (int i = 0; i < ND; i++) wr(i, i + 1);
      wr(6, 9);
      wr(7, 9);
      repeat (3 * ND * DW) @(negedge clk);
      wait_sel(3);
      chk("R10 digit3 value", int'(bcd_out), 4);
      // R6: mid-slot write not visible
      @(negedge clk);
      wr(3, 7);
      chk("R6 held mid-slot", int'(bcd_out), 4);
      wait_sel(4);
      wait_sel(3);
      chk("R6 shown after boundary", int'(bcd_out), 7);
      // R9: values above nine pass verbatim
      wr(0, 12);
      wr(5, 15);
      wait_sel(1);
      wait_sel(0);
      chk("R9 twelve", int'(bcd_out), 12);
      wait_sel(5);
      chk("R9 fifteen", int'(bcd_out), 15);
      // R8: addresses 6 and 7 touched nothing
      wait_sel(1);
      chk("R8 digit1 intact", int'(bcd_out), 2);
      // R5: disabled, dark but still scanning
      sys_en = 1'b0;
      @(negedge clk);
      begin
         int s0 = m_steps;
         repeat (4 * DW) @(negedge clk);
         chk("R5 dark", int'(digit_en), 0);
         chk("R5 scan runs", (m_steps > s0) ? 1 : 0, 1);
      end
      sys_en = 1'b1;
      repeat (2 * ND * DW) @(negedge clk);
      // R1: reset mid-run clears stored digits
      rst = 1'b1;
      @(negedge clk);
      chk("R1 re-reset sel", int'(sel_code), 0);
      chk("R1 re-reset bcd", int'(bcd_out), 0);
      rst = 1'b0;
      repeat (ND * DW) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule